// File: doc/BRIEF.md
# SPI Frame Upload Sequencer

This block is an SPI master that pulls one received frame out of an external radio's frame buffer and places it in a local byte RAM. A one-cycle `start` pulse lowers chip select and sends the frame-read command. The byte that comes back during that command is the frame length. The sequencer checks the length against a lower and an upper bound. If the length is in range, it clocks in exactly that many payload bytes and writes each one to the RAM. Each byte also goes through a CRC-CCITT as it arrives. One more byte, the link-quality value, is read after the payload, and then chip select is released.

When a frame finishes, the block presents the length, the link-quality byte and a CRC-good flag, and pulses `done` for one cycle. A frame whose length is out of range ends right after the command byte and reports zero for all three results. The stored payload can be read back through a synchronous read port.

The controller has six states:
- `ST_IDLE` waits for `start`.
- `ST_CMD` shifts the command out and the length in.
- `ST_PAYLOAD` streams the payload bytes.
- `ST_QUAL` fetches the link-quality byte.
- `ST_REJECT` reports an out-of-range frame.
- `ST_REPORT` reports a complete frame.

The transitions are:
- idle-to-command on `start`.
- command-to-payload when the length is in range.
- command-to-reject when the length is out of range.
- payload-to-payload after each byte but the last.
- payload-to-quality after the last byte.
- quality-to-report after the link-quality byte.
- reject-to-idle and report-to-idle, both unconditional.

Top module: `frame_fetch_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, and `done`, `busy`, `frame_len`, `frame_lqi` and `crc_ok` are all 0.
- R2: For an accepted frame of length L, `spi_cs_n` stays low from the command byte through the link-quality byte, with exactly 8*(L+2) rising SCK edges. It is released only on a byte boundary.
- R3: The SPI link runs in mode 0, MSB first. SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. The first MOSI byte of every transfer is `READ_CMD` (default 0x20).
- R4: The byte received while the command is sent is the frame length. The frame is accepted only when MIN_LEN <= length <= MAX_LEN, both bounds inclusive, and MAX_LEN defaults to 127.
- R5: An out-of-range length releases `spi_cs_n` right after the command byte, after 8 SCK edges only. The block then pulses `done` with `frame_len` = 0, `frame_lqi` = 0 and `crc_ok` = 0.
- R6: Payload byte k (counted from 0) is written to RAM address k. Driving `rd_addr` = k returns it on `rd_data` one clock later.
- R7: The byte that follows the last payload byte is reported on `frame_lqi`.
- R8: The CRC is computed byte-wise, LSB first, with the reflected polynomial 0x8408 and a start value of 0. `crc_ok` is 1 only when the final value equals `GOOD_RESIDUE` (default 0x0000), which is the case when the payload ends with its own CRC appended low byte first.
- R9: `done` is high for exactly one cycle per transfer. A `start` pulse while `busy` is high starts nothing: it causes no second chip-select fall and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to fetch a frame |
| busy | output | 1 | High while a transfer is in progress |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the radio |
| spi_miso | input | 1 | Serial data from the radio |
| rd_addr | input | $clog2(MAX_LEN) | Payload RAM read address |
| rd_data | output | 8 | Payload RAM read data, one cycle after the address |
| frame_len | output | 8 | Length of the last frame, 0 if rejected |
| frame_lqi | output | 8 | Link-quality byte of the last frame, 0 if rejected |
| crc_ok | output | 1 | CRC residue matched for the last frame |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CLK_DIV` = 2, `MIN_LEN` = 3 and `MAX_LEN` = 127. The short clock divider keeps a full 127-byte upload near 4,200 cycles, so the upper bound can be run byte for byte. The lowered minimum allows a frame holding one data byte plus its two CRC bytes, which exercises the accept side of the lower bound next to a rejected length of 2. A behavioural slave in the bench feeds MISO from a queue. It counts SCK edges against chip select and captures MOSI. The CRC residue, the RAM contents and the link-quality byte are checked against values the bench computes itself.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAYLOAD,
        ST_QUAL,
        ST_REJECT,
        ST_REPORT
    } fetch_state_t;

    // One byte of reflected CRC update, LSB of the byte first.
    function automatic logic [15:0] crc_refl_byte(input logic [15:0] crc_in,
                                                  input logic [7:0]  data,
                                                  input logic [15:0] poly);
        logic [15:0] c;
        c = crc_in ^ {8'h00, data};
        for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ poly;
            else      c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/ffs_spi_shift.sv
module ffs_spi_shift #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV - 1);

    logic          active;
    logic [CW-1:0] half_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic          sck_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    tx_sr    <= tx_byte;
                    half_cnt <= '0;
                    bit_cnt  <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (half_cnt == HALF_LAST) begin
                half_cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_sr <= {rx_sr[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                    end
                end
            end else begin
                half_cnt <= half_cnt + CW'(1);
            end
        end
    end

    assign byte_done = done_q;
    assign rx_byte   = rx_sr;
    assign sck       = sck_q;
    assign mosi      = tx_sr[7];

endmodule

// File: rtl/ffs_crc_unit.sv
module ffs_crc_unit
    import ffs_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '0;
        else if (clr) crc_q <= '0;
        else if (en)  crc_q <= crc_refl_byte(crc_q, din, POLY);
    end

    assign crc = crc_q;

endmodule

// File: rtl/ffs_byte_ram.sv
module ffs_byte_ram #(
    parameter int DEPTH = 127,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
        rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
    end

endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
    import ffs_pkg::*;
#(
    parameter int          CLK_DIV      = 4,
    parameter int          MIN_LEN      = 5,
    parameter int          MAX_LEN      = 127,
    parameter logic [7:0]  READ_CMD     = 8'h20,
    parameter logic [7:0]  FILL_BYTE    = 8'h00,
    parameter logic [15:0] CRC_POLY     = 16'h8408,
    parameter logic [15:0] GOOD_RESIDUE = 16'h0000,
    localparam int         AW           = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          spi_sck,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    frame_len,
    output logic [7:0]    frame_lqi,
    output logic          crc_ok,
    output logic          done
);
    localparam logic [7:0] LEN_LO = 8'(MIN_LEN);
    localparam logic [7:0] LEN_HI = 8'(MAX_LEN);

    fetch_state_t state_q, state_d;

    logic        byte_done;
    logic [7:0]  rx_byte;
    logic        sh_go;
    logic [7:0]  sh_tx;
    logic        len_ok;
    logic        last_byte;
    logic [15:0] crc_val;
    logic        crc_clr;
    logic        crc_en;

    logic        cs_n_q;
    logic [7:0]  len_q;
    logic [7:0]  idx_q;
    logic [7:0]  lqi_q;

    // Length window and end-of-payload detection.
    assign len_ok    = (rx_byte >= LEN_LO) && (rx_byte <= LEN_HI);
    assign last_byte = ((idx_q + 8'd1) == len_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CMD;
            ST_CMD:     if (byte_done) state_d = len_ok ? ST_PAYLOAD : ST_REJECT;
            ST_PAYLOAD: if (byte_done && last_byte) state_d = ST_QUAL;
            ST_QUAL:    if (byte_done) state_d = ST_REPORT;
            ST_REJECT:  state_d = ST_IDLE;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Byte launch control for the shifter.
    always_comb begin
        sh_go   = 1'b0;
        sh_tx   = FILL_BYTE;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sh_go   = start;
                sh_tx   = READ_CMD;
                crc_clr = start;
            end
            ST_CMD:     sh_go = byte_done && len_ok;
            ST_PAYLOAD: begin
                sh_go  = byte_done;
                crc_en = byte_done;
            end
            default: ;
        endcase
    end

    // Outputs and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q    <= 1'b1;
            len_q     <= '0;
            idx_q     <= '0;
            lqi_q     <= '0;
            frame_len <= '0;
            frame_lqi <= '0;
            crc_ok    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cs_n_q <= 1'b0;
                    idx_q  <= '0;
                end
                ST_CMD: if (byte_done) begin
                    len_q <= rx_byte;
                    if (!len_ok) cs_n_q <= 1'b1;
                end
                ST_PAYLOAD: if (byte_done) idx_q <= idx_q + 8'd1;
                ST_QUAL: if (byte_done) begin
                    lqi_q  <= rx_byte;
                    cs_n_q <= 1'b1;
                end
                ST_REJECT: begin
                    frame_len <= '0;
                    frame_lqi <= '0;
                    crc_ok    <= 1'b0;
                    done      <= 1'b1;
                end
                ST_REPORT: begin
                    frame_len <= len_q;
                    frame_lqi <= lqi_q;
                    crc_ok    <= (crc_val == GOOD_RESIDUE);
                    done      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign spi_cs_n = cs_n_q;

    ffs_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (sh_go),
        .tx_byte   (sh_tx),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    ffs_crc_unit #(.POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (rx_byte),
        .crc   (crc_val)
    );

    ffs_byte_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (crc_en),
        .waddr (idx_q[AW-1:0]),
        .wdata (rx_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/ffs_checker.sv
module ffs_checker #(
    parameter int MIN_LEN = 5,
    parameter int MAX_LEN = 127
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic       done,
    input logic       crc_ok,
    input logic [7:0] frame_len,
    input logic [7:0] frame_lqi
);
    logic        sck_d;
    logic [11:0] rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            rises <= '0;
        end else begin
            sck_d <= spi_sck;
            if (spi_cs_n)                rises <= '0;
            else if (spi_sck && !sck_d)  rises <= rises + 12'd1;
        end
    end

    // R3: SCK rests low whenever the radio is deselected
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R2: chip select is released only after whole bytes
    a_r2_whole_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (rises[2:0] == 3'd0) && (rises != 12'd0));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request during a transfer does not restart it
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> !$fell(spi_cs_n));

    // R2: an idle block never selects the radio
    a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R5: a zero length report carries zero quality and a failed CRC
    a_r5_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_len == 8'd0) |-> (frame_lqi == 8'd0) && !crc_ok);

    // R4: every reported nonzero length lies inside the window
    a_r4_len_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frame_len != 8'd0) |->
            (int'(frame_len) >= MIN_LEN) && (int'(frame_len) <= MAX_LEN));

endmodule

bind frame_fetch_seq ffs_checker #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_ffs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .done      (done),
    .crc_ok    (crc_ok),
    .frame_len (frame_len),
    .frame_lqi (frame_lqi)
);

// File: tb/frame_fetch_seq_test.sv
module frame_fetch_seq_test;
    localparam int         DIV   = 2;
    localparam int         LO    = 3;
    localparam int         HI    = 127;
    localparam logic [7:0] CMD   = 8'h20;
    localparam int         AWB   = $clog2(HI);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, spi_sck, spi_cs_n, spi_mosi, crc_ok, done;
    logic spi_miso = 1'b0;
    logic [AWB-1:0] rd_addr = '0;
    logic [7:0] rd_data, frame_len, frame_lqi;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    frame_fetch_seq #(.CLK_DIV(DIV), .MIN_LEN(LO), .MAX_LEN(HI), .READ_CMD(CMD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_len(frame_len), .frame_lqi(frame_lqi), .crc_ok(crc_ok), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural radio: serves a byte queue on MISO, mode 0, MSB first.
    logic [7:0] stream [$];
    logic [7:0] cur_byte;
    int         bitpos;
    int         sck_rises;
    int         cs_falls;
    int         mosi_bits;
    logic [7:0] mosi_sr;
    logic [7:0] first_mosi;

    function automatic logic [7:0] next_byte();
        if (stream.size() > 0) return stream.pop_front();
        return 8'h00;
    endfunction

    always @(negedge spi_cs_n) begin
        cur_byte  = next_byte();
        bitpos    = 7;
        spi_miso  = cur_byte[7];
        sck_rises = 0;
        mosi_bits = 0;
        cs_falls++;
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (bitpos == 0) begin
                cur_byte = next_byte();
                bitpos   = 7;
            end else begin
                bitpos--;
            end
            spi_miso = cur_byte[bitpos];
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sck_rises++;
            mosi_sr = {mosi_sr[6:0], spi_mosi};
            mosi_bits++;
            if (mosi_bits == 8) first_mosi = mosi_sr;
        end
    end

    // Per-clock comparison against the expected line behaviour.
    logic prev_done = 1'b0;
    int   done_cnt  = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(spi_cs_n && spi_sck), "R3 sck low while deselected", int'(spi_sck), 0);
            chk(!(done && prev_done), "R9 done width", 2, 1);
            if (done) done_cnt++;
        end
        prev_done = done;
    end

    function automatic logic [15:0] ref_crc(input logic [7:0] bytes [$]);
        logic [15:0] c = 16'h0000;
        foreach (bytes[i]) begin
            c ^= {8'h00, bytes[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    function automatic void make_good(ref logic [7:0] q [$], input int n, input int seed);
        logic [15:0] f;
        q = {};
        for (int i = 0; i < n - 2; i++) q.push_back(8'((i * 37 + seed) ^ (i << 3)));
        f = ref_crc(q);
        q.push_back(f[7:0]);
        q.push_back(f[15:8]);
    endfunction

    task automatic run_frame(input logic [7:0] len, input logic [7:0] pl [$],
                             input logic [7:0] lqi, input bit poke);
        bit accept;
        int n;
        accept = (int'(len) >= LO) && (int'(len) <= HI);
        stream = {};
        stream.push_back(len);
        foreach (pl[i]) stream.push_back(pl[i]);
        stream.push_back(lqi);
        cs_falls = 0;
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R9 done seen", int'(done), 1);
        chk(first_mosi == CMD, "R3 command byte", int'(first_mosi), int'(CMD));
        if (accept) begin
            chk(sck_rises == 8 * (int'(len) + 2), "R2 sck edges", sck_rises, 8 * (int'(len) + 2));
            chk(frame_len == len, "R4 length", int'(frame_len), int'(len));
            chk(frame_lqi == lqi, "R7 lqi", int'(frame_lqi), int'(lqi));
            chk(crc_ok == (ref_crc(pl) == 16'h0000), "R8 crc_ok",
                int'(crc_ok), int'(ref_crc(pl) == 16'h0000));
        end else begin
            chk(sck_rises == 8, "R5 sck edges on reject", sck_rises, 8);
            chk(frame_len == 8'd0, "R5 length zero", int'(frame_len), 0);
            chk(frame_lqi == 8'd0, "R5 lqi zero", int'(frame_lqi), 0);
            chk(!crc_ok, "R5 crc_ok low", int'(crc_ok), 0);
        end
        repeat (150) @(negedge clk);
        chk(cs_falls == 1, "R9 single selection", cs_falls, 1);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);
        chk(spi_cs_n && !busy, "R2 released", int'(spi_cs_n), 1);
        if (accept) begin
            for (int i = 0; i < int'(len); i++) begin
                rd_addr = AWB'(i);
                @(negedge clk);
                chk(rd_data == pl[i], "R6 ram byte", int'(rd_data), int'(pl[i]));
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hang expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pl [$];
        repeat (3) @(negedge clk);
        chk(spi_cs_n === 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
        chk(spi_sck === 1'b0, "R1 sck", int'(spi_sck), 0);
        chk(done === 1'b0 && busy === 1'b0, "R1 done busy", int'(done | busy), 0);
        chk(frame_len === 8'd0 && frame_lqi === 8'd0 && crc_ok === 1'b0,
            "R1 results", int'(frame_len), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        make_good(pl, 3, 5);       run_frame(8'd3, pl, 8'hA5, 1'b0);   // R4 lower bound
        pl = {8'h11, 8'h22};       run_frame(8'd2, pl, 8'h77, 1'b0);   // R5 below window
        pl = {};                   run_frame(8'd0, pl, 8'h33, 1'b0);   // R5 zero length
        pl = {};                   run_frame(8'd128, pl, 8'h44, 1'b0); // R5 above window
        pl = {};                   run_frame(8'd255, pl, 8'h55, 1'b0); // R5 all ones
        make_good(pl, 127, 9);     run_frame(8'd127, pl, 8'h3C, 1'b0); // R4 upper bound
        make_good(pl, 10, 1);
        pl[4] = pl[4] ^ 8'h10;     run_frame(8'd10, pl, 8'hC3, 1'b0);  // R8 corrupt
        make_good(pl, 20, 77);     run_frame(8'd20, pl, 8'hFF, 1'b1);  // R9 start while busy
        make_good(pl, 6, 200);     run_frame(8'd6, pl, 8'h00, 1'b0);   // R7 zero lqi

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule